// File: doc/BRIEF.md
# System Clock Source Switcher

This block picks the system clock from up to eight free-running oscillator inputs and passes it through an integer post-divider. Each oscillator comes with a ready flag. Software controls the block through a small register window. It writes a requested-source code and sets a start bit. The block then checks that the requested oscillator is ready and moves the output over without a glitch. It clears the start bit when it is done, whether the switch took place or was refused. A read-back field always shows which source is actually driving the output.

The post-divider ratio is a four-bit field plus one. When a new ratio is written, the block can reach it in single steps. Stepping is enabled separately for rising and falling ratios, and each step waits a programmable hold time. A busy flag covers the whole ratio change. Both control registers are write-protected. A two-word key opens a window that admits exactly one write. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, the control register reads 0, the present ratio field reads 0, and `clk_out` runs at the period of source 0.
- R2: Setting the start bit (control bit 3, with requested source in bits 2:0) begins a changeover. On success, the current-source field (bits 6:4) equals the request and the start bit reads 0.
- R3: No two oscillator gates are ever enabled at once. After a changeover, `clk_out` runs at the new source's period times the ratio.
- R4: A request for a source whose ready flag is low is refused. The start bit clears, and both the current-source field and the output period are unchanged.
- R5: The division ratio is the target field (divider register bits 3:0) plus one. The `clk_out` period is the source period times that ratio.
- R6: The busy flag (divider register bit 9) is high from the write of a new target until the new ratio is in effect, and low otherwise.
- R7: Writes to the control register (address 1) or the divider register (address 2) are ignored unless the write window is open.
- R8: Writing 0xA5C3 and then 0x3C5A to address 0 in consecutive cycles opens the window. It closes after one accepted write. A key with a gap between its words opens nothing.
- R9: When the ratio rises with up-stepping enabled (bit 7), the present ratio (bits 13:10) rises by one per step. Consecutive steps are at least (slew field bits 6:4 + 1) × STEP_BASE bus cycles apart.
- R10: When the ratio falls with down-stepping enabled (bit 8), the present ratio falls by one per step, with the same minimum spacing.
- R11: Without stepping enabled for the direction of change, the present ratio jumps to the target in one move.
- R12: Address 0 and address 3 read 0. Reads of the two control registers return the layouts given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | NSRC | Oscillator clock inputs |
| osc_rdy | input | NSRC | Per-oscillator ready flags (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| clk_out | output | 1 | Selected and divided system clock |

## Verification
Two of the block's functions can run at the same moment: a stepped ratio change and a source changeover. While the changeover has the gated clock paused, the ratio handshake into the output domain stalls and must resume afterwards. The bench provokes this by writing a stepped target and starting a switch in the very next write window. It judges the result by the final busy and start bits and by the measured output period, which must equal the new source period times the new ratio.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int DATA_W = 16;
  localparam int SRC_W  = 3;
  localparam int DIV_W  = 4;
  localparam int SLEW_W = 3;

  localparam logic [1:0] A_KEY = 2'd0;
  localparam logic [1:0] A_OSC = 2'd1;
  localparam logic [1:0] A_DIV = 2'd2;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 16'hA5C3;
  localparam logic [DATA_W-1:0] KEY_SECOND = 16'h3C5A;

  typedef enum logic [1:0] {SW_BOOT, SW_IDLE, SW_DROP, SW_RAISE} sw_state_e;

  typedef struct packed {
    logic              dn_en;
    logic              up_en;
    logic [SLEW_W-1:0] slew;
    logic [DIV_W-1:0]  tgt;
  } div_ctl_t;
endpackage

// File: rtl/sck_regs.sv
module sck_regs
  import sysclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              sw_fin,
  input  logic [SRC_W-1:0]  cur_src,
  input  logic              div_busy,
  input  logic [DIV_W-1:0]  div_now,
  output logic [SRC_W-1:0]  req_src,
  output logic              sw_go,
  output div_ctl_t          div_ctl,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CTL_W = $bits(div_ctl_t);

  logic key_half, win_open, is_ctl_wr, take, key_hit1, key_hit2;

  assign key_hit1  = wr_en && (wr_addr == A_KEY) && (wr_data == KEY_FIRST);
  assign key_hit2  = wr_en && (wr_addr == A_KEY) && (wr_data == KEY_SECOND);
  assign is_ctl_wr = wr_en && ((wr_addr == A_OSC) || (wr_addr == A_DIV));
  assign take      = is_ctl_wr && win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_half <= 1'b0;
      win_open <= 1'b0;
    end else begin
      key_half <= key_hit1;
      if (key_half && key_hit2) win_open <= 1'b1;
      else if (take)            win_open <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_src <= '0;
      sw_go   <= 1'b0;
      div_ctl <= '0;
    end else begin
      if (take && wr_addr == A_OSC) req_src <= wr_data[SRC_W-1:0];
      if (take && wr_addr == A_OSC && wr_data[SRC_W]) sw_go <= 1'b1;
      else if (sw_fin)                                sw_go <= 1'b0;
      if (take && wr_addr == A_DIV) div_ctl <= div_ctl_t'(wr_data[CTL_W-1:0]);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_OSC: rd_data = {{(DATA_W-2*SRC_W-1){1'b0}}, cur_src, sw_go, req_src};
      A_DIV: rd_data = {{(DATA_W-CTL_W-DIV_W-1){1'b0}}, div_now, div_busy, div_ctl};
      default: rd_data = '0;
    endcase
  end

  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl_wr && !win_open) |=> ($stable(req_src) && $stable(div_ctl)));
  p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !win_open);
  p_go_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_go && !sw_fin) |=> sw_go);
endmodule

// File: rtl/sck_src_gate.sv
module sck_src_gate (
  input  logic bus_clk,
  input  logic rst_n,
  input  logic osc_clk,
  input  logic want,
  output logic en,
  output logic en_fb
);
  logic w1, w2, f1;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      w1 <= 1'b0;
      w2 <= 1'b0;
    end else begin
      w1 <= want;
      w2 <= w1;
    end
  end

  always_ff @(negedge osc_clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= w2;
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      f1    <= 1'b0;
      en_fb <= 1'b0;
    end else begin
      f1    <= en;
      en_fb <= f1;
    end
  end
endmodule

// File: rtl/sck_switch_fsm.sv
module sck_switch_fsm
  import sysclk_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [SRC_W-1:0] req,
  input  logic [NSRC-1:0]  rdy_async,
  input  logic [NSRC-1:0]  en_fb,
  output logic [NSRC-1:0]  want,
  output logic [SRC_W-1:0] cur,
  output logic             fin
);
  sw_state_e       st;
  logic [SRC_W-1:0] tgt;
  logic [NSRC-1:0]  rdy_m, rdy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_m <= '0;
      rdy_s <= '0;
    end else begin
      rdy_m <= rdy_async;
      rdy_s <= rdy_m;
    end
  end

  always_comb begin
    fin = 1'b0;
    case (st)
      SW_IDLE:  fin = go && (!rdy_s[req] || (req == cur));
      SW_RAISE: fin = en_fb[tgt];
      default:  fin = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SW_BOOT;
      tgt  <= '0;
      cur  <= '0;
      want <= NSRC'(1);
    end else begin
      case (st)
        SW_BOOT: if (en_fb[cur]) st <= SW_IDLE;
        SW_IDLE: begin
          if (go && rdy_s[req] && (req != cur)) begin
            tgt  <= req;
            want <= '0;
            st   <= SW_DROP;
          end
        end
        SW_DROP: begin
          if (!en_fb[cur]) begin
            want      <= '0;
            want[tgt] <= 1'b1;
            st        <= SW_RAISE;
          end
        end
        SW_RAISE: begin
          if (en_fb[tgt]) begin
            cur <= tgt;
            st  <= SW_IDLE;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  p_one_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_fb));
  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SW_IDLE && go && !rdy_s[req]) |=> $stable(cur));
  p_cur_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> ($past(st) == SW_RAISE));
endmodule

// File: rtl/sck_slew.sv
module sck_slew
  import sysclk_pkg::*;
#(
  parameter int STEP_BASE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  tgt,
  input  logic [SLEW_W-1:0] slew_sel,
  input  logic              up_en,
  input  logic              dn_en,
  input  logic              ack_async,
  output logic [DIV_W-1:0]  ratio,
  output logic              req_tog,
  output logic              busy
);
  localparam int HOLD_MAX = (1 << SLEW_W) * STEP_BASE;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);

  logic              ack_m, ack_s, pending, going_up, use_step;
  logic [HOLD_W-1:0] hold, lim;

  assign lim      = HOLD_W'((int'(slew_sel) + 1) * STEP_BASE - 1);
  assign pending  = (req_tog != ack_s);
  assign going_up = (tgt > ratio);
  assign use_step = going_up ? up_en : dn_en;
  assign busy     = pending || (ratio != tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m   <= 1'b0;
      ack_s   <= 1'b0;
      ratio   <= '0;
      req_tog <= 1'b0;
      hold    <= '0;
    end else begin
      ack_m <= ack_async;
      ack_s <= ack_m;
      if (!pending && ratio != tgt) begin
        if (!use_step) begin
          ratio   <= tgt;
          req_tog <= ~req_tog;
          hold    <= '0;
        end else if (hold == lim) begin
          ratio   <= going_up ? ratio + 1'b1 : ratio - 1'b1;
          req_tog <= ~req_tog;
          hold    <= '0;
        end else begin
          hold <= hold + 1'b1;
        end
      end else begin
        hold <= '0;
      end
    end
  end

  p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && ratio < tgt) |=> ({1'b0, ratio} <= {1'b0, $past(ratio)} + 5'd1));
  p_step_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_en && ratio > tgt) |=> ({1'b0, ratio} + 5'd1 >= {1'b0, $past(ratio)}));
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(ratio));
endmodule

// File: rtl/sck_postdiv.sv
module sck_postdiv
  import sysclk_pkg::*;
(
  input  logic             mux_clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_bus,
  input  logic             req_async,
  output logic             ack_tog,
  output logic             clk_out
);
  logic             r1, r2;
  logic [DIV_W-1:0] applied, cnt, cnt_nxt;
  logic [DIV_W:0]   half;
  logic             div_q;

  assign cnt_nxt = (cnt >= applied) ? '0 : cnt + 1'b1;
  assign half    = ({1'b0, applied} + 1'b1) >> 1;

  always_ff @(posedge mux_clk or negedge rst_n) begin
    if (!rst_n) begin
      r1      <= 1'b0;
      r2      <= 1'b0;
      ack_tog <= 1'b0;
      applied <= '0;
      cnt     <= '0;
      div_q   <= 1'b0;
    end else begin
      r1      <= req_async;
      r2      <= r1;
      ack_tog <= r2;
      if (r2 != ack_tog) applied <= ratio_bus;
      cnt   <= cnt_nxt;
      div_q <= ({1'b0, cnt_nxt} < half);
    end
  end

  assign clk_out = (applied == '0) ? mux_clk : div_q;

  p_cnt_wrap_r5: assert property (@(posedge mux_clk) disable iff (!rst_n)
    ($past(cnt) >= $past(applied)) |-> (cnt == '0));
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int NSRC      = 8,
  parameter int STEP_BASE = 4
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   osc_clk,
  input  logic [NSRC-1:0]   osc_rdy,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_out
);
  logic [NSRC-1:0]  want, en, en_fb;
  logic [SRC_W-1:0] req_src, cur_src;
  logic             sw_go, sw_fin, div_busy, req_tog, ack_tog, mux_clk;
  logic [DIV_W-1:0] ratio;
  div_ctl_t         div_ctl;

  sck_regs u_regs (
    .clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .sw_fin(sw_fin), .cur_src(cur_src),
    .div_busy(div_busy), .div_now(ratio), .req_src(req_src), .sw_go(sw_go),
    .div_ctl(div_ctl), .rd_data(rd_data)
  );

  sck_switch_fsm #(.NSRC(NSRC)) u_fsm (
    .clk(bus_clk), .rst_n(rst_n), .go(sw_go), .req(req_src),
    .rdy_async(osc_rdy), .en_fb(en_fb), .want(want), .cur(cur_src), .fin(sw_fin)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    sck_src_gate u_gate (
      .bus_clk(bus_clk), .rst_n(rst_n), .osc_clk(osc_clk[g]),
      .want(want[g]), .en(en[g]), .en_fb(en_fb[g])
    );
  end

  assign mux_clk = |(osc_clk & en);

  sck_slew #(.STEP_BASE(STEP_BASE)) u_slew (
    .clk(bus_clk), .rst_n(rst_n), .tgt(div_ctl.tgt), .slew_sel(div_ctl.slew),
    .up_en(div_ctl.up_en), .dn_en(div_ctl.dn_en), .ack_async(ack_tog),
    .ratio(ratio), .req_tog(req_tog), .busy(div_busy)
  );

  sck_postdiv u_div (
    .mux_clk(mux_clk), .rst_n(rst_n), .ratio_bus(ratio), .req_async(req_tog),
    .ack_tog(ack_tog), .clk_out(clk_out)
  );
endmodule

// File: tb/sysclk_switch_tb.sv
module sysclk_switch_tb;
  localparam int CLK_HALF = 5;
  localparam int STEP_BASE = 4;

  logic        bus_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  osc_clk;
  logic [7:0]  osc_rdy = 8'b1110_1111;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  int exp_src = 0;
  int exp_div = 0;

  always #CLK_HALF bus_clk = ~bus_clk;

  for (genvar g = 0; g < 8; g++) begin : g_osc
    logic c;
    initial c = 1'b0;
    always #(3 + g) c = ~c;
    assign osc_clk[g] = c;
  end

  sysclk_switch #(.NSRC(8), .STEP_BASE(STEP_BASE)) u_dut (
    .bus_clk(bus_clk), .rst_n(rst_n), .osc_clk(osc_clk), .osc_rdy(osc_rdy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .clk_out(clk_out)
  );

  function automatic int exp_period(input int src, input int div);
    return (6 + 2 * src) * (div + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'hA5C3;
    @(negedge bus_clk);
    wr_data = 16'h3C5A;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge bus_clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, d);
      if (!d[3]) begin
        rd(2'd2, d);
        if (!d[9]) break;
      end
    end
    repeat (30) @(negedge bus_clk);
  endtask

  task automatic chk_period(input int exp, input string req);
    longint t0, t1;
    repeat (2) @(posedge clk_out);
    t0 = $time;
    @(posedge clk_out);
    t1 = $time;
    check((t1 - t0) == exp, req, int'(t1 - t0), exp);
  endtask

  task automatic set_div(input int tgt, input int slew, input bit up, input bit dn);
    unlock();
    wr(2'd2, {7'd0, dn, up, slew[2:0], tgt[3:0]});
  endtask

  task automatic do_switch(input int src);
    unlock();
    wr(2'd1, {12'd0, 1'b1, src[2:0]});
  endtask

  // watch present ratio after a target write; stepped: expect unit moves
  task automatic watch(input int tgt, input int hold, input bit stepped, input string req);
    logic [15:0] d;
    int last, last_cyc, moves;
    bit bad;
    last = exp_div; last_cyc = 0; moves = 0; bad = 0;
    for (int i = 1; i < 3000; i++) begin
      rd(2'd2, d);
      if (int'(d[13:10]) != last) begin
        moves++;
        if (stepped) begin
          if ((int'(d[13:10]) - last != 1 && last - int'(d[13:10]) != 1) || (i - last_cyc < hold)) bad = 1;
        end
        last = int'(d[13:10]);
        last_cyc = i;
      end
      if (int'(d[13:10]) == tgt && !d[9]) break;
    end
    check(!bad, req, moves, stepped ? ((tgt > exp_div) ? tgt - exp_div : exp_div - tgt) : 1);
    check(last == tgt, req, last, tgt);
    if (!stepped) check(moves == 1, req, moves, 1);
    exp_div = tgt;
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd2024));
    repeat (5) @(negedge bus_clk);
    rst_n = 1'b1;
    repeat (30) @(negedge bus_clk);

    // R1 reset state
    rd(2'd1, d); check(d == 16'h0, "R1", d, 0);
    rd(2'd2, d); check(d[13:10] == 4'd0, "R1", d[13:10], 0);
    chk_period(exp_period(0, 0), "R1");
    // R12 unused addresses
    rd(2'd0, d); check(d == 16'h0, "R12", d, 0);
    rd(2'd3, d); check(d == 16'h0, "R12", d, 0);

    // R7 locked write ignored
    wr(2'd1, 16'h000A);
    rd(2'd1, d); check(d == 16'h0, "R7", d, 0);
    // R8 key with a gap opens nothing
    wr(2'd0, 16'hA5C3);
    wr(2'd0, 16'h3C5A);
    wr(2'd2, 16'h0003);
    rd(2'd2, d); check(d[3:0] == 4'd0, "R8", d[3:0], 0);
    // R8 window admits one write only
    unlock();
    wr(2'd2, 16'h0002);
    wr(2'd2, 16'h0005);
    rd(2'd2, d); check(d[3:0] == 4'd2, "R8", d[3:0], 2);
    rd(2'd2, d); check(d[9] == 1'b1 || d[13:10] == 4'd2, "R6", d[9], 1);
    wait_idle();
    exp_div = 2;
    rd(2'd2, d); check(d[9] == 1'b0, "R6", d[9], 0);
    chk_period(exp_period(0, 2), "R5");

    // R2/R3 switch to source 3
    do_switch(3);
    wait_idle();
    rd(2'd1, d); check(d[6:4] == 3'd3 && !d[3], "R2", d[6:0], 7'h33);
    exp_src = 3;
    chk_period(exp_period(3, 2), "R3");

    // R4 refused: source 4 not ready
    do_switch(4);
    wait_idle();
    rd(2'd1, d); check(d[6:4] == 3'd3 && !d[3], "R4", d[6:4], 3);
    chk_period(exp_period(3, 2), "R4");

    // R9 stepped rise 2 -> 7, slew 1
    set_div(7, 1, 1'b1, 1'b0);
    watch(7, 2 * STEP_BASE, 1'b1, "R9");
    // R10 stepped fall 7 -> 1, slew 2
    set_div(1, 2, 1'b0, 1'b1);
    watch(1, 3 * STEP_BASE, 1'b1, "R10");
    // R11 jump up without stepping
    set_div(9, 1, 1'b0, 1'b1);
    watch(9, 0, 1'b0, "R11");
    // R11 jump down without stepping
    set_div(4, 1, 1'b1, 1'b0);
    watch(4, 0, 1'b0, "R11");
    wait_idle();
    chk_period(exp_period(3, 4), "R5");

    // overlap: stepped change and switch together (R3, R5, R6)
    set_div(8, 0, 1'b1, 1'b1);
    do_switch(6);
    wait_idle();
    exp_src = 6; exp_div = 8;
    rd(2'd2, d); check(d[13:10] == 4'd8 && !d[9], "R6", d[13:9], 16);
    rd(2'd1, d); check(d[6:4] == 3'd6, "R2", d[6:4], 6);
    chk_period(exp_period(6, 8), "R3");

    // random mix (R2, R4, R5)
    for (int k = 0; k < 8; k++) begin
      int s, v;
      s = int'($urandom_range(0, 7));
      v = int'($urandom_range(0, 15));
      set_div(v, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      do_switch(s);
      wait_idle();
      exp_div = v;
      if (osc_rdy[s]) exp_src = s;
      rd(2'd1, d); check(int'(d[6:4]) == exp_src, osc_rdy[s] ? "R2" : "R4", d[6:4], exp_src);
      chk_period(exp_period(exp_src, exp_div), "R5");
    end

    finish_run();
  end
endmodule